// File: doc/BRIEF.md
# Coprocessor Mailbox Command Engine

The engine is the host-side half of a command handshake with an embedded coprocessor. A one-cycle start pulse picks one of three preset commands. The engine then works through a small register window over a simple bus master port. It writes a five-word message into shared message RAM and rings the to-coprocessor mailbox. It polls the to-host mailbox until a nonzero response code appears or a poll budget runs out, reads the five reply words back, and releases the to-host mailbox by writing zero to it.

When the sequence ends, the engine presents a status word. Timeout takes priority over a checksum mismatch, and a checksum mismatch takes priority over whatever code the coprocessor returned. It also presents the reply argument word, split into a pointer type and an offset. The pointer type tells the host whether the offset points into message RAM or into data memory, or whether the reply is a protocol fault. Poll spacing is given in clock cycles, so the engine fits any clock rate.

Top module: `mbx_cmd_engine`

## Requirements
- R1: After synchronous reset: busy, done and bus_req are 0, and status and reply_arg are 0.
- R2: After an accepted start, the engine issues five back-to-back writes to addresses 0x100, 0x104, 0x108, 0x10C and 0x110, in that order. The data words are header 1, the command word, argument count 1, argument 0, and their 32-bit sum. The (command, argument 0) pair is (1,1) for cmd_sel 0, (2,1) for cmd_sel 1 and (2,2) for cmd_sel 2. The next request after these is a write of 1 to 0x10.
- R3: The engine then reads 0x14 repeatedly. Between the end of one poll and the next poll request there are at least POLL_GAP cycles with no request. Polling stops at the first nonzero read.
- R4: After a nonzero poll, the engine reads 0x100 to 0x110 once each, in order. It then writes 0 to 0x14, and done pulses for one cycle on the cycle after that write.
- R5: If POLL_MAX polls all return zero, status is 0x80000010 and no message RAM read is issued. The write of 0 to 0x14 and the done pulse still follow.
- R6: If the reply words 0 to 3 do not sum (mod 2^32) to reply word 4, status is 0x80000004 regardless of the returned code.
- R7: Otherwise status equals the nonzero code read from 0x14, for example 0x1 for success or 0x80000002 for an invalid command.
- R8: reply_arg is reply word 3, or 0 after a timeout. ptr_type is reply_arg[31:28] and ptr_offset is reply_arg[27:0]. ptr_in_msgram is 1 only for type 1, and ptr_fatal is 1 for any type above 1.
- R9: A start is ignored while busy is high or when cmd_sel is 3. busy rises on the cycle after an accepted start and stays high through the done cycle.
- R10: A read request is never followed by another request until bus_rvalid has returned its data. Writes complete in their request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run a command |
| cmd_sel | input | 2 | Preset command select, 0 to 2 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse; results valid from here |
| status | output | 32 | Final status code |
| reply_arg | output | 32 | Reply argument word |
| ptr_type | output | 4 | Reply pointer type field |
| ptr_offset | output | 28 | Reply pointer offset field |
| ptr_in_msgram | output | 1 | Offset is relative to message RAM |
| ptr_fatal | output | 1 | Pointer type is not a legal value |
| bus_req | output | 1 | Bus request, one cycle per transaction |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_addr | output | ADDR_W | Byte address in the register window |
| bus_wdata | output | 32 | Write data |
| bus_rvalid | input | 1 | Read data valid, one cycle |
| bus_rdata | input | 32 | Read data |

## Verification
The assertions check the following on every cycle:
- the doorbell write carries 1 and the release write carries 0;
- a read request is never followed directly by another request;
- done only occurs while busy;
- a timed-out run always latches the timeout code;
- the pointer decode never flags message RAM and fatal together.

Some behaviours only the bench scenarios can show. These are the exact order and content of the message words for each preset, the poll spacing, the number of polls before timeout, and the absence of a readback after a timeout. They also include the priority of checksum failure over a returned code, and starts that are ignored while busy or with an illegal selector. For these the bench compares every bus write against an expected queue built from the requirements.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int MSG_WORDS = 5;

    localparam int OFS_TO_CP   = 'h10;
    localparam int OFS_TO_HOST = 'h14;
    localparam int OFS_MSG     = 'h100;

    typedef logic [31:0] word_t;

    localparam word_t ST_TIMEOUT = 32'h8000_0010;
    localparam word_t ST_CKSUM   = 32'h8000_0004;

    typedef enum logic [3:0] {
        S_IDLE, S_WMSG, S_RING, S_PREQ, S_PWAIT,
        S_GAP,  S_RREQ, S_RWAIT, S_REL, S_FIN
    } seq_state_e;

    typedef struct packed {
        logic [3:0]  kind;
        logic [27:0] offset;
    } reply_ptr_t;

    function automatic logic sel_legal(logic [1:0] sel);
        return sel != 2'd3;
    endfunction

    // Word idx of the outgoing message for preset sel
    function automatic word_t cmd_word(logic [1:0] sel, logic [2:0] idx);
        word_t opc, arg;
        opc = (sel == 2'd0) ? 32'd1 : 32'd2;
        arg = (sel == 2'd2) ? 32'd2 : 32'd1;
        case (idx)
            3'd0:    return 32'd1;
            3'd1:    return opc;
            3'd2:    return 32'd1;
            3'd3:    return arg;
            default: return 32'd2 + opc + arg;
        endcase
    endfunction

endpackage

// File: rtl/mbx_seq_ctrl.sv
module mbx_seq_ctrl
    import mbx_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int POLL_MAX = 200000,
    parameter int POLL_GAP = 500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        cmd_sel,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output word_t             bus_wdata,
    input  logic              bus_rvalid,
    input  word_t             bus_rdata,
    output logic              clr_o,
    output logic              cap_vld_o,
    output logic [2:0]        cap_idx_o,
    output logic              latch_o,
    output logic              tmo_o,
    output word_t             code_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int PC_W = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
    localparam int GP_W = $clog2(POLL_GAP + 1);
    localparam logic [2:0] LAST = 3'(MSG_WORDS - 1);

    seq_state_e      state;
    logic [1:0]      sel_q;
    logic [2:0]      idx;
    logic [PC_W-1:0] poll_cnt;
    logic [GP_W-1:0] gap_cnt;
    logic            tmo_q;
    word_t           code_q;
    logic            accept;

    assign accept = (state == S_IDLE) && start && sel_legal(cmd_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            sel_q    <= '0;
            idx      <= '0;
            poll_cnt <= '0;
            gap_cnt  <= '0;
            tmo_q    <= 1'b0;
            code_q   <= '0;
        end else begin
            case (state)
                S_IDLE: if (accept) begin
                    sel_q    <= cmd_sel;
                    idx      <= '0;
                    poll_cnt <= '0;
                    tmo_q    <= 1'b0;
                    code_q   <= '0;
                    state    <= S_WMSG;
                end
                S_WMSG: begin
                    if (idx == LAST) begin
                        idx   <= '0;
                        state <= S_RING;
                    end else begin
                        idx <= idx + 3'd1;
                    end
                end
                S_RING: state <= S_PREQ;
                S_PREQ: state <= S_PWAIT;
                S_PWAIT: if (bus_rvalid) begin
                    if (bus_rdata != '0) begin
                        code_q <= bus_rdata;
                        idx    <= '0;
                        state  <= S_RREQ;
                    end else if (poll_cnt == PC_W'(POLL_MAX - 1)) begin
                        tmo_q <= 1'b1;
                        state <= S_REL;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                        gap_cnt  <= '0;
                        state    <= S_GAP;
                    end
                end
                S_GAP: begin
                    if (gap_cnt == GP_W'(POLL_GAP - 1)) state <= S_PREQ;
                    else gap_cnt <= gap_cnt + 1'b1;
                end
                S_RREQ: state <= S_RWAIT;
                S_RWAIT: if (bus_rvalid) begin
                    if (idx == LAST) begin
                        state <= S_REL;
                    end else begin
                        idx   <= idx + 3'd1;
                        state <= S_RREQ;
                    end
                end
                S_REL:   state <= S_FIN;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        case (state)
            S_WMSG: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = ADDR_W'(OFS_MSG) + ADDR_W'({idx, 2'b00});
                bus_wdata = cmd_word(sel_q, idx);
            end
            S_RING: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = ADDR_W'(OFS_TO_CP);
                bus_wdata = 32'd1;
            end
            S_PREQ: begin
                bus_req  = 1'b1;
                bus_addr = ADDR_W'(OFS_TO_HOST);
            end
            S_RREQ: begin
                bus_req  = 1'b1;
                bus_addr = ADDR_W'(OFS_MSG) + ADDR_W'({idx, 2'b00});
            end
            S_REL: begin
                bus_req  = 1'b1;
                bus_we   = 1'b1;
                bus_addr = ADDR_W'(OFS_TO_HOST);
            end
            default: ;
        endcase
    end

    assign clr_o     = accept;
    assign cap_vld_o = (state == S_RWAIT) && bus_rvalid;
    assign cap_idx_o = idx;
    assign latch_o   = (state == S_REL);
    assign tmo_o     = tmo_q;
    assign code_o    = code_q;
    assign busy_o    = (state != S_IDLE);
    assign done_o    = (state == S_FIN);

    // R10
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we) |=> !bus_req);
    // R2
    ring_value_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_addr == ADDR_W'(OFS_TO_CP)) |-> bus_wdata == 32'd1);
    // R4
    release_value_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_addr == ADDR_W'(OFS_TO_HOST)) |-> bus_wdata == '0);
    // R9
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o);
endmodule

// File: rtl/mbx_reply_eval.sv
module mbx_reply_eval
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       cap_vld,
    input  logic [2:0] cap_idx,
    input  word_t      cap_data,
    input  logic       latch,
    input  logic       tmo,
    input  word_t      code,
    output word_t      status_o,
    output word_t      arg_o,
    output logic [3:0] ptr_type_o,
    output logic [27:0] ptr_offset_o,
    output logic       in_msgram_o,
    output logic       fatal_o
);
    word_t      words [MSG_WORDS];
    word_t      sum;
    reply_ptr_t ptr;

    generate
        for (genvar g = 0; g < MSG_WORDS; g++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst || clr) words[g] <= '0;
                else if (cap_vld && cap_idx == 3'(g)) words[g] <= cap_data;
            end
        end
    endgenerate

    always_comb begin
        sum = '0;
        for (int i = 0; i < MSG_WORDS - 1; i++) sum = sum + words[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_o <= '0;
            arg_o    <= '0;
        end else if (latch) begin
            if (tmo)                         status_o <= ST_TIMEOUT;
            else if (sum != words[MSG_WORDS-1]) status_o <= ST_CKSUM;
            else                             status_o <= code;
            arg_o <= tmo ? '0 : words[3];
        end
    end

    assign ptr          = reply_ptr_t'(arg_o);
    assign ptr_type_o   = ptr.kind;
    assign ptr_offset_o = ptr.offset;
    assign in_msgram_o  = (ptr.kind == 4'd1);
    assign fatal_o      = (ptr.kind > 4'd1);

    // R5
    timeout_code_chk: assert property (@(posedge clk) disable iff (rst)
        (latch && tmo) |=> status_o == ST_TIMEOUT);
    // R8
    ptr_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_msgram_o && fatal_o));
endmodule

// File: rtl/mbx_cmd_engine.sv
module mbx_cmd_engine
    import mbx_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int POLL_MAX = 200000,
    parameter int POLL_GAP = 500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        cmd_sel,
    output logic              busy,
    output logic              done,
    output logic [31:0]       status,
    output logic [31:0]       reply_arg,
    output logic [3:0]        ptr_type,
    output logic [27:0]       ptr_offset,
    output logic              ptr_in_msgram,
    output logic              ptr_fatal,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_rvalid,
    input  logic [31:0]       bus_rdata
);
    logic       clr, cap_vld, latch, tmo;
    logic [2:0] cap_idx;
    word_t      code;

    mbx_seq_ctrl #(
        .ADDR_W(ADDR_W), .POLL_MAX(POLL_MAX), .POLL_GAP(POLL_GAP)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .cmd_sel(cmd_sel),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .clr_o(clr), .cap_vld_o(cap_vld), .cap_idx_o(cap_idx),
        .latch_o(latch), .tmo_o(tmo), .code_o(code),
        .busy_o(busy), .done_o(done)
    );

    mbx_reply_eval u_eval (
        .clk(clk), .rst(rst), .clr(clr), .cap_vld(cap_vld),
        .cap_idx(cap_idx), .cap_data(bus_rdata), .latch(latch),
        .tmo(tmo), .code(code), .status_o(status), .arg_o(reply_arg),
        .ptr_type_o(ptr_type), .ptr_offset_o(ptr_offset),
        .in_msgram_o(ptr_in_msgram), .fatal_o(ptr_fatal)
    );
endmodule

// File: tb/mbx_cmd_engine_tb.sv
module mbx_cmd_engine_tb;
    localparam int ADDR_W = 12;
    localparam int PMAX   = 6;
    localparam int PGAP   = 3;

    logic clk = 0, rst = 1, start = 0;
    logic [1:0] cmd_sel = 0;
    logic busy, done, ptr_in_msgram, ptr_fatal, bus_req, bus_we;
    logic [31:0] status, reply_arg, bus_wdata;
    logic [3:0] ptr_type;
    logic [27:0] ptr_offset;
    logic [ADDR_W-1:0] bus_addr;
    logic bus_rvalid = 0;
    logic [31:0] bus_rdata = 0;

    always #5 clk = ~clk;

    mbx_cmd_engine #(.ADDR_W(ADDR_W), .POLL_MAX(PMAX), .POLL_GAP(PGAP)) u_dut (
        .clk(clk), .rst(rst), .start(start), .cmd_sel(cmd_sel), .busy(busy),
        .done(done), .status(status), .reply_arg(reply_arg), .ptr_type(ptr_type),
        .ptr_offset(ptr_offset), .ptr_in_msgram(ptr_in_msgram), .ptr_fatal(ptr_fatal),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata));

    int checks = 0, errors = 0, cyc = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Responder model state
    logic [31:0] ram [5];
    logic [31:0] reply [5];
    logic [31:0] rcode = 0;
    logic        tocp = 0, respond = 0;
    int          zero_polls = 0, resp_after = 0, rd_lat = 1;
    logic        pend = 0;
    int          pend_cnt = 0;
    logic [31:0] pend_data = 0;
    // Observation
    int n_poll = 0, n_msgrd = 0, n_ring = 0, n_req = 0, last_poll = -1, min_gap = 1000;
    int exp_addr[$];
    logic [31:0] exp_data[$];

    always @(negedge clk) begin
        cyc++;
        if (bus_rvalid) bus_rvalid <= 0;
        if (pend) begin
            if (pend_cnt == 0) begin
                bus_rvalid <= 1; bus_rdata <= pend_data; pend <= 0;
            end else pend_cnt <= pend_cnt - 1;
        end
        if (!rst && bus_req) begin
            n_req++;
            // R10: no request while a read is still pending
            chk("R10 request while read pending", {31'd0, pend}, 32'd0);
            if (bus_we) begin
                if (exp_addr.size() == 0) begin
                    chk("R2/R4 unexpected write addr", 32'(bus_addr), 32'hFFFF);
                end else begin
                    chk("R2/R4 write address", 32'(bus_addr), 32'(exp_addr.pop_front()));
                    chk("R2/R4 write data", bus_wdata, exp_data.pop_front());
                end
                if (bus_addr == 12'h010) begin tocp = bus_wdata[0]; n_ring++; zero_polls = 0; end
                else if (bus_addr >= 12'h100) ram[(bus_addr - 12'h100) >> 2] = bus_wdata;
            end else begin
                pend <= 1; pend_cnt <= rd_lat - 1;
                if (bus_addr == 12'h014) begin
                    n_poll++;
                    if (last_poll >= 0 && cyc - last_poll < min_gap) min_gap = cyc - last_poll;
                    last_poll = cyc;
                    if (tocp && respond) begin
                        if (zero_polls == resp_after) begin
                            for (int i = 0; i < 5; i++) ram[i] = reply[i];
                            tocp = 0;
                            pend_data <= rcode;
                        end else begin
                            zero_polls++; pend_data <= 0;
                        end
                    end else pend_data <= 0;
                end else begin
                    n_msgrd++;
                    pend_data <= ram[(bus_addr - 12'h100) >> 2];
                end
            end
        end
    end

    task automatic set_reply(logic [31:0] arg, logic [31:0] code, logic bad_sum);
        reply[0] = 2; reply[1] = 7; reply[2] = 1; reply[3] = arg;
        reply[4] = 2 + 7 + 1 + arg + (bad_sum ? 32'd9 : 32'd0);
        rcode = code;
    endtask

    task automatic run(logic [1:0] sel, logic resp, int after, int lat, logic restart,
                       logic [31:0] exp_st, logic [31:0] exp_arg);
        logic [31:0] opc, arg;
        int wait_c;
        opc = (sel == 0) ? 1 : 2;
        arg = (sel == 2) ? 2 : 1;
        exp_addr = {}; exp_data = {};
        exp_addr.push_back('h100); exp_data.push_back(1);
        exp_addr.push_back('h104); exp_data.push_back(opc);
        exp_addr.push_back('h108); exp_data.push_back(1);
        exp_addr.push_back('h10C); exp_data.push_back(arg);
        exp_addr.push_back('h110); exp_data.push_back(2 + opc + arg);
        exp_addr.push_back('h010); exp_data.push_back(1);
        exp_addr.push_back('h014); exp_data.push_back(0);
        respond = resp; resp_after = after; rd_lat = lat;
        n_poll = 0; n_msgrd = 0; n_ring = 0; last_poll = -1; min_gap = 1000;
        cmd_sel = sel; start = 1;
        @(negedge clk); start = 0;
        chk("R9 busy after accepted start", {31'd0, busy}, 32'd1);
        if (restart) begin
            repeat (3) @(negedge clk);
            cmd_sel = 2'd0; start = 1;
            @(negedge clk); start = 0;
        end
        wait_c = 0;
        while (!done && wait_c < 2000) begin
            chk("R9 busy held until done", {31'd0, busy}, 32'd1);
            @(negedge clk); wait_c++;
        end
        chk("R4 done reached", {31'd0, done}, 32'd1);
        chk("R9 busy during done", {31'd0, busy}, 32'd1);
        chk("R5/R6/R7 status", status, exp_st);
        chk("R8 reply_arg", reply_arg, exp_arg);
        chk("R8 ptr_type", 32'(ptr_type), 32'(exp_arg[31:28]));
        chk("R8 ptr_offset", 32'(ptr_offset), 32'(exp_arg[27:0]));
        chk("R8 in_msgram", {31'd0, ptr_in_msgram}, {31'd0, exp_arg[31:28] == 4'd1});
        chk("R8 fatal", {31'd0, ptr_fatal}, {31'd0, exp_arg[31:28] > 4'd1});
        chk("R2/R4 all writes seen", 32'(exp_addr.size()), 0);
        chk("R9 single ring", 32'(n_ring), 1);
        chk("R3 poll count", 32'(n_poll), resp ? 32'(after + 1) : 32'(PMAX));
        chk("R4/R5 message reads", 32'(n_msgrd), resp ? 32'd5 : 32'd0);
        if (n_poll > 1) chk("R3 poll spacing", {31'd0, min_gap >= PGAP + 2}, 32'd1);
        @(negedge clk);
        chk("R9 busy falls after done", {31'd0, busy}, 32'd0);
        chk("R4 done one cycle", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1
        chk("R1 busy", {31'd0, busy}, 0);
        chk("R1 done", {31'd0, done}, 0);
        chk("R1 bus_req", {31'd0, bus_req}, 0);
        chk("R1 status", status, 0);
        chk("R1 reply_arg", reply_arg, 0);
        // R2 R7 R8: preset 0, success, message RAM pointer
        set_reply(32'h1000_0040, 32'h1, 0);
        run(2'd0, 1, 0, 1, 0, 32'h1, 32'h1000_0040);
        // preset 1, data memory pointer, slower reads, several zero polls (R3)
        set_reply(32'h0000_0200, 32'h1, 0);
        run(2'd1, 1, 3, 2, 0, 32'h1, 32'h0000_0200);
        // R6: bad checksum overrides success code
        set_reply(32'h1000_0008, 32'h1, 1);
        run(2'd2, 1, 1, 1, 0, 32'h8000_0004, 32'h1000_0008);
        // R6: bad checksum overrides error code as well
        set_reply(32'h1000_0008, 32'h8000_0002, 1);
        run(2'd0, 1, 0, 1, 0, 32'h8000_0004, 32'h1000_0008);
        // R7: coprocessor error passed through
        set_reply(32'h0000_0010, 32'h8000_0002, 0);
        run(2'd2, 1, 0, 2, 0, 32'h8000_0002, 32'h0000_0010);
        // R8: illegal pointer type is fatal
        set_reply(32'h3ABC_DEF0, 32'h1, 0);
        run(2'd1, 1, 0, 1, 0, 32'h1, 32'h3ABC_DEF0);
        // R5: no answer -> timeout
        run(2'd0, 0, 0, 1, 0, 32'h8000_0010, 32'h0);
        // R9: start while busy ignored
        set_reply(32'h1000_0004, 32'h1, 0);
        run(2'd2, 1, 2, 1, 1, 32'h1, 32'h1000_0004);
        // R9: illegal selector ignored
        n_req = 0;
        cmd_sel = 2'd3; start = 1;
        @(negedge clk); start = 0;
        repeat (10) begin
            chk("R9 sel 3 ignored busy", {31'd0, busy}, 0);
            @(negedge clk);
        end
        chk("R9 sel 3 no bus traffic", 32'(n_req), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule